// File: doc/BRIEF.md
# Shift and Rotate Execution Unit with Status Flags

This unit carries out the seven shift and rotate operations of an integer execution pipeline on an operand of 8, 16, 32 or 64 bits. Operand size is chosen per request. Each request carries the operand, a count, an operation code and the current status flag word. The unit returns the shifted or rotated operand together with the updated flag word. Carry, overflow, sign, zero, parity and auxiliary-carry are computed exactly for each operation. The overflow value is defined for every count, including counts above one.

Requests enter through a valid/ready handshake and are registered. The result is offered one cycle after acceptance and is held until the consumer takes it. A narrow operand lives in the low bits of the 64-bit data bus. Only those bits are read, and the bits above the selected size are driven to zero on the result.

Top module: `shrot_unit`

## Requirements
- R1: The count is reduced by AND with (operand width − 1) before use, so only its low 3, 4, 5 or 6 bits count for sizes 8, 16, 32 or 64 (in_size codes 0, 1, 2, 3).
- R2: When the reduced count is zero, or the operation code is 7 (no operation), the result equals the input operand and the flag word equals the input flag word.
- R3: Rotate left (code 0) rotates within the operand width. Carry is result bit 0. Overflow is the result's top bit XOR that carry.
- R4: Rotate right (code 1) rotates within the operand width. Carry is the result's top bit. Overflow is the top bit XOR result bit (width − 2).
- R5: Rotate left through carry (code 2) and rotate right through carry (code 3) rotate the (width + 1)-bit value formed by the carry flag above the operand. The new carry is the bit that lands above the operand. Overflow is the result's top bit XOR the new carry.
- R6: For the four rotates, only carry (bit 0) and overflow (bit 11) of the flag word may change.
- R7: Shift left (code 4) fills with zeros. Carry is original bit (width − count). Overflow is the result's top bit XOR carry.
- R8: Logical shift right (code 5) fills with zeros. Arithmetic shift right (code 6) fills with the original sign bit. For both, carry is original bit (count − 1). Overflow is the original top bit for the logical shift and 0 for the arithmetic shift.
- R9: For the three shifts: sign (bit 7) is the result's top bit. Zero (bit 6) is set when the result is 0. Parity (bit 2) is set when result bits 7:0 hold an even number of ones. Auxiliary carry (bit 4) is cleared.
- R10: Flag word bits outside those named above are copied unchanged from the input flag word.
- R11: Result bits at and above the operand width are zero.
- R12: A request is taken on a clock edge where in_valid and in_ready are both high. out_valid rises on that edge, and the result holds stable until out_ready is high. in_ready is high whenever the output register is empty or is being emptied. After reset, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_op | input | 3 | Operation code (0 rotl, 1 rotr, 2 rcl, 3 rcr, 4 shl, 5 shr, 6 sar, 7 none) |
| in_size | input | 2 | Operand size code (0:8, 1:16, 2:32, 3:64 bits) |
| in_data | input | 64 | Operand, right-aligned |
| in_count | input | 8 | Shift or rotate count before reduction |
| in_flags | input | 32 | Incoming status flag word |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Result, upper bits zero |
| out_flags | output | 32 | Updated status flag word |

## Verification
Every result and flag word is due exactly one clock edge after the edge that accepts its request. The bench drives a request half a cycle before an edge, lowers in_valid after that edge, and compares out_data and out_flags at the following falling edge. The outputs are settled there and the consumer has not yet taken them. For the stall case, out_ready is held low for several cycles and the same values are compared at each falling edge. Expected values come from a bench model that applies the operation one bit step at a time, with the count reduced by a modulo, rather than with the unit's wide shifts.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  localparam int unsigned SR_DW   = 64;
  localparam int unsigned SR_CW   = 8;
  localparam int unsigned SR_FW   = 32;

  // Flag word bit positions
  localparam int unsigned FL_CF = 0;
  localparam int unsigned FL_PF = 2;
  localparam int unsigned FL_AF = 4;
  localparam int unsigned FL_ZF = 6;
  localparam int unsigned FL_SF = 7;
  localparam int unsigned FL_OF = 11;

  typedef enum logic [2:0] {
    OP_ROL = 3'd0,
    OP_ROR = 3'd1,
    OP_RCL = 3'd2,
    OP_RCR = 3'd3,
    OP_SHL = 3'd4,
    OP_SHR = 3'd5,
    OP_SAR = 3'd6,
    OP_NOP = 3'd7
  } sr_op_e;

  // Operand width in bits for a size code
  function automatic logic [SR_CW-1:0] size_bits(logic [1:0] sz);
    return SR_CW'(8) << sz;
  endfunction

  // Mask covering the live operand bits
  function automatic logic [SR_DW-1:0] lane_mask(logic [1:0] sz);
    logic [SR_DW-1:0] m;
    case (sz)
      2'd0:    m = 64'h0000_0000_0000_00FF;
      2'd1:    m = 64'h0000_0000_0000_FFFF;
      2'd2:    m = 64'h0000_0000_FFFF_FFFF;
      default: m = 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
    return m;
  endfunction

  // Single bit of a vector at a run-time position
  function automatic logic bit_at(logic [SR_DW-1:0] v, logic [SR_CW-1:0] i);
    return |(v & (64'd1 << i));
  endfunction

  function automatic logic wide_bit_at(logic [2*SR_DW-1:0] v, logic [SR_CW-1:0] i);
    return |(v & (128'd1 << i));
  endfunction

  // 1 when the byte holds an even number of ones
  function automatic logic even_ones(logic [7:0] b);
    return ~^b;
  endfunction

  function automatic logic is_rotate(sr_op_e op);
    return (op == OP_ROL) || (op == OP_ROR) || (op == OP_RCL) || (op == OP_RCR);
  endfunction

  function automatic logic is_shift(sr_op_e op);
    return (op == OP_SHL) || (op == OP_SHR) || (op == OP_SAR);
  endfunction

endpackage

// File: rtl/shrot_count.sv
module shrot_count
  import shrot_pkg::*;
#(
  parameter int unsigned CW = SR_CW
) (
  input  logic [1:0]    size,
  input  logic [CW-1:0] count_raw,
  output logic [CW-1:0] count_eff,
  output logic          count_zero
);
  logic [CW-1:0] limit;

  always_comb begin
    limit      = CW'(size_bits(size)) - CW'(1);
    count_eff  = count_raw & limit;
    count_zero = (count_eff == '0);
  end
endmodule

// File: rtl/shrot_core.sv
module shrot_core
  import shrot_pkg::*;
(
  input  sr_op_e            op,
  input  logic [1:0]        size,
  input  logic [SR_DW-1:0]  data,
  input  logic [SR_CW-1:0]  cnt,
  input  logic              cf_in,
  output logic [SR_DW-1:0]  res,
  output logic              res_msb,
  output logic              cf_out,
  output logic              of_out
);
  localparam int unsigned WW = 2 * SR_DW;

  logic [SR_CW-1:0] wv, back, back1;
  logic [SR_DW-1:0] m, x, sx;
  logic [WW-1:0]    v, r, m1;
  logic             x_msb;

  always_comb begin
    wv    = size_bits(size);
    m     = lane_mask(size);
    x     = data & m;
    x_msb = bit_at(x, wv - SR_CW'(1));
    back  = wv - cnt;
    back1 = wv + SR_CW'(1) - cnt;
    v     = {{SR_DW{1'b0}}, x} | ({{(WW-1){1'b0}}, cf_in} << wv);
    m1    = (WW'(1) << (wv + SR_CW'(1))) - WW'(1);
    sx    = x_msb ? (x | ~m) : x;
    r     = '0;
    res   = x;
    cf_out = cf_in;

    case (op)
      OP_ROL: begin
        res    = ((x << cnt) | (x >> back)) & m;
        cf_out = res[0];
      end
      OP_ROR: begin
        res    = ((x >> cnt) | (x << back)) & m;
        cf_out = bit_at(res, wv - SR_CW'(1));
      end
      OP_RCL: begin
        r      = ((v << cnt) | (v >> back1)) & m1;
        res    = r[SR_DW-1:0] & m;
        cf_out = wide_bit_at(r, wv);
      end
      OP_RCR: begin
        r      = ((v >> cnt) | (v << back1)) & m1;
        res    = r[SR_DW-1:0] & m;
        cf_out = wide_bit_at(r, wv);
      end
      OP_SHL: begin
        res    = (x << cnt) & m;
        cf_out = bit_at(x, back);
      end
      OP_SHR: begin
        res    = x >> cnt;
        cf_out = bit_at(x, cnt - SR_CW'(1));
      end
      OP_SAR: begin
        res    = 64'($signed(sx) >>> cnt) & m;
        cf_out = bit_at(x, cnt - SR_CW'(1));
      end
      default: begin
        res    = x;
        cf_out = cf_in;
      end
    endcase

    res_msb = bit_at(res, wv - SR_CW'(1));

    case (op)
      OP_ROL:                 of_out = res_msb ^ res[0];
      OP_ROR:                 of_out = res_msb ^ bit_at(res, wv - SR_CW'(2));
      OP_RCL, OP_RCR, OP_SHL: of_out = res_msb ^ cf_out;
      OP_SHR:                 of_out = x_msb;
      default:                of_out = 1'b0;
    endcase
  end
endmodule

// File: rtl/shrot_flags.sv
module shrot_flags
  import shrot_pkg::*;
(
  input  sr_op_e            op,
  input  logic              skip,
  input  logic [SR_FW-1:0]  flags_in,
  input  logic [SR_DW-1:0]  res,
  input  logic              res_msb,
  input  logic              cf,
  input  logic              of,
  output logic [SR_FW-1:0]  flags_out
);
  localparam logic [SR_FW-1:0] ROT_SET =
    (SR_FW'(1) << FL_CF) | (SR_FW'(1) << FL_OF);
  localparam logic [SR_FW-1:0] SHF_SET = ROT_SET |
    (SR_FW'(1) << FL_PF) | (SR_FW'(1) << FL_AF) |
    (SR_FW'(1) << FL_ZF) | (SR_FW'(1) << FL_SF);

  logic [SR_FW-1:0] base;

  always_comb begin
    flags_out = flags_in;
    base      = flags_in;
    if (!skip && is_rotate(op)) begin
      base      = flags_in & ~ROT_SET;
      flags_out = base | (SR_FW'(cf) << FL_CF) | (SR_FW'(of) << FL_OF);
    end else if (!skip && is_shift(op)) begin
      base      = flags_in & ~SHF_SET;
      flags_out = base
                | (SR_FW'(cf)                 << FL_CF)
                | (SR_FW'(of)                 << FL_OF)
                | (SR_FW'(res_msb)            << FL_SF)
                | (SR_FW'(res == '0)          << FL_ZF)
                | (SR_FW'(even_ones(res[7:0])) << FL_PF);
    end
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [2:0]  in_op,
  input  logic [1:0]  in_size,
  input  logic [63:0] in_data,
  input  logic [7:0]  in_count,
  input  logic [31:0] in_flags,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [63:0] out_data,
  output logic [31:0] out_flags
);
  sr_op_e           op_e;
  logic [SR_CW-1:0] cnt_eff;
  logic             cnt_zero, skip, core_msb, core_cf, core_of;
  logic [SR_DW-1:0] core_res, nxt_data, in_lane;
  logic [SR_FW-1:0] nxt_flags;
  logic             accept;
  logic             vld_q;
  logic [SR_DW-1:0] data_q;
  logic [SR_FW-1:0] flags_q;
  logic [1:0]       size_q;

  assign op_e    = sr_op_e'(in_op);
  assign in_lane = in_data & lane_mask(in_size);

  shrot_count #(.CW(SR_CW)) u_count (
    .size       (in_size),
    .count_raw  (in_count),
    .count_eff  (cnt_eff),
    .count_zero (cnt_zero)
  );

  shrot_core u_core (
    .op      (op_e),
    .size    (in_size),
    .data    (in_data),
    .cnt     (cnt_eff),
    .cf_in   (in_flags[FL_CF]),
    .res     (core_res),
    .res_msb (core_msb),
    .cf_out  (core_cf),
    .of_out  (core_of)
  );

  assign skip     = cnt_zero || (op_e == OP_NOP);
  assign nxt_data = skip ? in_lane : core_res;

  shrot_flags u_flags (
    .op        (op_e),
    .skip      (skip),
    .flags_in  (in_flags),
    .res       (core_res),
    .res_msb   (core_msb),
    .cf        (core_cf),
    .of        (core_of),
    .flags_out (nxt_flags)
  );

  assign in_ready = !vld_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      data_q  <= '0;
      flags_q <= '0;
      size_q  <= '0;
    end else if (accept) begin
      vld_q   <= 1'b1;
      data_q  <= nxt_data;
      flags_q <= nxt_flags;
      size_q  <= in_size;
    end else if (out_ready) begin
      vld_q   <= 1'b0;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;
  assign out_flags = flags_q;

  // R2: nothing changes for a zero effective count
  a_r2_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && skip) |-> (nxt_flags == in_flags && nxt_data == in_lane));

  // R3: rotate-left carry follows result bit 0
  a_r3_rol_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !skip && op_e == OP_ROL) |-> (nxt_flags[FL_CF] == nxt_data[0]));

  // R6: rotates leave all but carry and overflow alone
  a_r6_rot_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_rotate(op_e)) |->
      ((nxt_flags ^ in_flags) & ~((32'd1 << FL_CF) | (32'd1 << FL_OF))) == 32'd0);

  // R8: arithmetic right shift never reports overflow
  a_r8_sar_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !skip && op_e == OP_SAR) |-> !nxt_flags[FL_OF]);

  // R9: zero flag agrees with the result, auxiliary carry is cleared
  a_r9_shift_zf: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !skip && is_shift(op_e)) |->
      (nxt_flags[FL_ZF] == (nxt_data == '0) && !nxt_flags[FL_AF]));

  // R11: no live bit above the operand width
  a_r11_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_data & ~lane_mask(size_q)) == '0));

  // R12: a stalled result stays put
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_flags)));

  // R12: an accepted request is offered on the next cycle
  a_r12_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: tb/tb_shrot_unit.sv
module tb_shrot_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [1:0]  in_size = '0;
  logic [63:0] in_data = '0;
  logic [7:0]  in_count = '0;
  logic [31:0] in_flags = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic [31:0] out_flags;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shrot_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_size(in_size), .in_data(in_data), .in_count(in_count),
    .in_flags(in_flags), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_flags(out_flags)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bench model: one bit step at a time, count reduced by modulo
  task automatic model(input int op, input int sz, input logic [63:0] d, input int cnt,
                       input logic [31:0] f, output logic [63:0] r, output logic [31:0] fo);
    int w = 8 << sz;
    int c = cnt % w;
    logic [63:0] m = '0;
    logic [63:0] x;
    logic cf, t, top, of;
    for (int i = 0; i < w; i++) m[i] = 1'b1;
    x  = d & m;
    fo = f;
    if (c == 0 || op == 7) begin
      r = x;
      return;
    end
    cf = f[0];
    for (int k = 0; k < c; k++) begin
      case (op)
        0: begin t = x[w-1]; x = ((x << 1) | 64'(t)) & m; end
        1: begin t = x[0];   x = (x >> 1) | (64'(t) << (w-1)); end
        2: begin t = x[w-1]; x = ((x << 1) | 64'(cf)) & m; cf = t; end
        3: begin t = x[0];   x = (x >> 1) | (64'(cf) << (w-1)); cf = t; end
        4: begin cf = x[w-1]; x = (x << 1) & m; end
        5: begin cf = x[0];   x = x >> 1; end
        default: begin cf = x[0]; t = x[w-1]; x = (x >> 1) | (64'(t) << (w-1)); end
      endcase
    end
    r   = x;
    top = x[w-1];
    case (op)
      0: begin cf = x[0]; of = top ^ cf; end
      1: begin cf = top;  of = top ^ x[w-2]; end
      5: of = d[w-1];
      6: of = 1'b0;
      default: of = top ^ cf;
    endcase
    fo[0]  = cf;
    fo[11] = of;
    if (op >= 4) begin
      fo[7] = top;
      fo[6] = (x == 0);
      fo[2] = ~^x[7:0];
      fo[4] = 1'b0;
    end
  endtask

  function automatic string tag_of(int op, int cnt, int w);
    if (cnt % w == 0 || op == 7) return (cnt >= w) ? "R1/R2" : "R2";
    case (op)
      0: return "R3/R6/R10/R11";
      1: return "R4/R6/R10/R11";
      2, 3: return "R5/R6/R10/R11";
      4: return "R7/R9/R10/R11";
      default: return "R8/R9/R10/R11";
    endcase
  endfunction

  task automatic run_one(input int op, input int sz, input logic [63:0] d, input int cnt,
                         input logic [31:0] f);
    logic [63:0] er;
    logic [31:0] ef;
    string tg = tag_of(op, cnt, 8 << sz);
    model(op, sz, d, cnt, f, er, ef);
    @(negedge clk);
    in_valid = 1'b1; in_op = 3'(op); in_size = 2'(sz);
    in_data = d; in_count = 8'(cnt); in_flags = f; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tg, " valid R12"}, 64'(out_valid), 64'd1);
    chk({tg, " data"}, out_data, er);
    chk({tg, " flags"}, 64'(out_flags), 64'(ef));
  endtask

  function automatic int count_pick(int i, int w);
    case (i)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 3;
      4: return w - 2;
      5: return w - 1;
      6: return w;       // R1: reduces to zero
      7: return w + 1;   // R1: reduces to one
      8: return w + 5;
      default: return 255;
    endcase
  endfunction

  function automatic logic [63:0] data_pick(int i);
    case (i)
      0: return 64'h8000_0000_8000_8081;
      1: return 64'h0123_4567_89AB_CDEF;
      2: return 64'hFFFF_FFFF_FFFF_FF7F;
      default: return 64'h5A5A_0000_C3C3_0001;
    endcase
  endfunction

  initial begin
    logic [63:0] er;
    logic [31:0] ef;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 reset out_valid", 64'(out_valid), 64'd0);
    chk("R12 reset in_ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int op = 0; op < 8; op++)
      for (int sz = 0; sz < 4; sz++)
        for (int ci = 0; ci < 10; ci++)
          for (int di = 0; di < 4; di++)
            for (int cf = 0; cf < 2; cf++)
              run_one(op, sz, data_pick(di), count_pick(ci, 8 << sz),
                      (cf != 0) ? 32'hFFFF_F7FF : 32'h0000_0800 | 32'hA5A0_0020);

    // R12: stall holds the result and blocks new requests
    model(2, 1, 64'h0000_0000_0000_9001, 5, 32'h0000_0001, er, ef);
    @(negedge clk);
    in_valid = 1'b1; in_op = 3'd2; in_size = 2'd1; in_data = 64'hFFFF_0000_0000_9001;
    in_count = 8'd5; in_flags = 32'h0000_0001; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R12 stall valid", 64'(out_valid), 64'd1);
      chk("R12 stall in_ready", 64'(in_ready), 64'd0);
      chk("R12/R11/R5 stall data", out_data, er);
      chk("R12 stall flags", 64'(out_flags), 64'(ef));
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk("R12 drained", 64'(out_valid), 64'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int n = 0; n < WATCHDOG; n++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R12 actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule